// File: doc/BRIEF.md
# Per-Core Escalating Watchdog Timer

This unit holds one countdown timer for each core of a small cluster. Software reaches it through a plain 64-bit register port with byte addresses. Each core's timer is reloaded from a 16-bit length value, which supplies the upper 16 bits of a 24-bit count. A shared prescaler, of 1024 cycles by default, sets the pace of the count. A core proves it is alive by poking its timer, which reloads the count.

When a core stops poking, each expiry of its timer takes its escalation one stage further. The first expiry posts an interrupt. The second sends out a one-cycle trap pulse, meant for a management agent. The third raises a reset request that stays asserted. The mode field sets how far the escalation may go. Interrupt status is shared by all cores, with one bit per core, and each bit is gated by an enable bit before it reaches the core's interrupt line.

Top module: `percore_watchdog`

## Requirements
- R1: After a synchronous reset all outputs are low, and every configuration word, the status word and the enable word read as zero.
- R2: Core c's configuration word sits at byte address 8*c. Mode is in bits [1:0], length in bits [19:4] and the live count in bits [43:20]. A write loads all three fields, and the other bits read back as zero.
- R3: A count that is running decrements once every 2^PRESC_LOG2 clock cycles (default 1024, a shared free-running prescaler). Mode 0 freezes the count.
- R4: A prescaler tick with the count at zero is an expiry. It reloads the count with length*256 and moves the stage up by one, unless the stage already equals the mode.
- R5: In mode 3 the first expiry sets the core's status bit. The second gives one trap pulse of a single cycle. The third asserts the reset request, which holds until reset.
- R6: Mode 1 stops escalation after the interrupt, and mode 2 stops it after the trap. The reset request never rises in those modes.
- R7: A write with bit 0 set to address 0x10000+8*c reloads core c's count with length*256 and returns its stage to zero. A write with bit 0 clear has no effect.
- R8: The status word at 0x200 has bit c for core c and is write-1-to-clear. A status set in the same cycle wins over a clear. Once cleared and poked, a bit fires again on the next first expiry.
- R9: Writing ones to 0x218 sets enable bits, and writing ones to 0x210 clears them. Both addresses read the enable word. irq_o equals status AND enable, registered, so it follows one cycle later.
- R10: Read data appears in the cycle after the request and is zero when there is no read. Reads of undefined or misaligned addresses, and of poke addresses, return zero. Writes to those addresses are ignored.
- R11: Each core's timer, stage, trap and reset request run independently of the other cores.
- R12: A configuration write takes priority over a poke, and a poke takes priority over a tick, for the same core in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, one cycle after the request |
| irq_o | output | NUM_CORES | Per-core interrupt (status AND enable) |
| trap_o | output | NUM_CORES | Per-core single-cycle trap pulse |
| rst_req_o | output | NUM_CORES | Per-core sticky reset request |

## Verification
Some properties are checked on every cycle:
- the reset request never drops once raised, and rises only in mode 3;
- a trap pulse never lasts two cycles;
- a count in mode 0 never moves;
- a status bit appears only after an expiry event;
- an interrupt line never rises without its enable bit;
- prescaler ticks are never back to back.

Other behaviour shows only in the bench's scenarios, where a behavioural model runs alongside the design and every output and every read word is compared on each clock:
- the exact tick spacing and the reload value;
- the order of the escalation stages;
- set-beats-clear on the status word;
- that poke data without bit 0 is ignored;
- how cores interact;
- that undefined addresses read as zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // configuration word field layout
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 2;
  localparam int LEN_LSB  = 4;
  localparam int LEN_W    = 16;
  localparam int CNT_LSB  = 20;
  localparam int CNT_W    = 24;
  localparam int FRAC_W   = CNT_W - LEN_W;

  // shared register byte addresses
  localparam int OFS_STATUS   = 32'h200;
  localparam int OFS_EN_CLR   = 32'h210;
  localparam int OFS_EN_SET   = 32'h218;
  localparam int OFS_POKE     = 32'h10000;
  localparam int WORD_STRIDE  = 8;

  typedef enum logic [MODE_W-1:0] {
    WM_OFF  = 2'd0,
    WM_IRQ  = 2'd1,
    WM_TRAP = 2'd2,
    WM_FULL = 2'd3
  } wd_mode_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRESC_LOG2 = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  logic [PRESC_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  assign tick_o = &div_q;

  // R3: ticks are spaced by the prescaler period, never adjacent
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdog_core_timer.sv
module wdog_core_timer
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic             poke_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic             irq_evt_o,
  output logic             trap_o,
  output logic             rst_req_o
);
  logic [MODE_W-1:0] mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        stage_q;
  logic              trap_q, rreq_q;

  logic [CNT_W-1:0]  reload;
  logic              running, expire, advance;
  logic [1:0]        stage_nx;

  always_comb begin
    reload   = {len_q, {FRAC_W{1'b0}}};
    running  = (mode_q != WM_OFF);
    expire   = tick_i && running && (cnt_q == '0) && !cfg_we_i && !poke_i;
    advance  = expire && (stage_q < mode_q);
    stage_nx = stage_q + 2'd1;
  end

  assign irq_evt_o = advance && (stage_nx == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= WM_OFF;
      len_q   <= '0;
      cnt_q   <= '0;
      stage_q <= '0;
      trap_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      trap_q <= advance && (stage_nx == 2'd2);
      if (advance && (stage_nx == 2'd3)) rreq_q <= 1'b1;
      if (cfg_we_i) begin
        mode_q <= cfg_mode_i;
        len_q  <= cfg_len_i;
        cnt_q  <= cfg_cnt_i;
      end else if (poke_i) begin
        cnt_q   <= reload;
        stage_q <= '0;
      end else if (tick_i && running) begin
        if (cnt_q == '0) begin
          cnt_q <= reload;
          if (advance) stage_q <= stage_nx;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign mode_o    = mode_q;
  assign len_o     = len_q;
  assign cnt_o     = cnt_q;
  assign trap_o    = trap_q;
  assign rst_req_o = rreq_q;

  // R5: reset request is sticky
  assert_rreq_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    rreq_q |=> rreq_q);
  // R5: trap is a single-cycle pulse
  assert_trap_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    trap_q |=> !trap_q);
  // R3: a stopped timer holds its count
  assert_frozen_count_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == WM_OFF && !cfg_we_i && !poke_i) |=> $stable(cnt_q));
  // R6: reset request only rises in full escalation mode
  assert_rreq_mode_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rreq_q) |-> ($past(mode_q) == WM_FULL));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 64
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  input  logic [NUM_CORES-1:0][MODE_W-1:0]  mode_i,
  input  logic [NUM_CORES-1:0][LEN_W-1:0]   len_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0]   cnt_i,
  input  logic [NUM_CORES-1:0]              irq_evt_i,
  output logic [NUM_CORES-1:0]              cfg_we_o,
  output logic [MODE_W-1:0]                 cfg_mode_o,
  output logic [LEN_W-1:0]                  cfg_len_o,
  output logic [CNT_W-1:0]                  cfg_cnt_o,
  output logic [NUM_CORES-1:0]              poke_o,
  output logic [DATA_W-1:0]                 rd_data_o,
  output logic [NUM_CORES-1:0]              irq_o
);
  logic [NUM_CORES-1:0] status_q, en_q, irq_q;
  logic [DATA_W-1:0]    rd_q, rd_mux;
  logic                 wr, rd;
  logic [NUM_CORES-1:0] clr_status, en_set, en_clr;
  logic                 unused_wdata;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  assign cfg_mode_o = req_wdata[MODE_LSB +: MODE_W];
  assign cfg_len_o  = req_wdata[LEN_LSB +: LEN_W];
  assign cfg_cnt_o  = req_wdata[CNT_LSB +: CNT_W];
  assign unused_wdata = ^req_wdata;

  always_comb begin
    cfg_we_o = '0;
    poke_o   = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (wr && req_addr == ADDR_W'(WORD_STRIDE * c)) cfg_we_o[c] = 1'b1;
      if (wr && req_addr == ADDR_W'(OFS_POKE + WORD_STRIDE * c) && req_wdata[0])
        poke_o[c] = 1'b1;
    end
    clr_status = (wr && req_addr == ADDR_W'(OFS_STATUS)) ? req_wdata[NUM_CORES-1:0] : '0;
    en_set     = (wr && req_addr == ADDR_W'(OFS_EN_SET)) ? req_wdata[NUM_CORES-1:0] : '0;
    en_clr     = (wr && req_addr == ADDR_W'(OFS_EN_CLR)) ? req_wdata[NUM_CORES-1:0] : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (req_addr == ADDR_W'(WORD_STRIDE * c)) begin
        rd_mux[MODE_LSB +: MODE_W] = mode_i[c];
        rd_mux[LEN_LSB +: LEN_W]   = len_i[c];
        rd_mux[CNT_LSB +: CNT_W]   = cnt_i[c];
      end
    end
    if (req_addr == ADDR_W'(OFS_STATUS)) rd_mux[NUM_CORES-1:0] = status_q;
    if (req_addr == ADDR_W'(OFS_EN_CLR) || req_addr == ADDR_W'(OFS_EN_SET))
      rd_mux[NUM_CORES-1:0] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      en_q     <= '0;
      irq_q    <= '0;
      rd_q     <= '0;
    end else begin
      status_q <= (status_q & ~clr_status) | irq_evt_i;
      en_q     <= (en_q & ~en_clr) | en_set;
      irq_q    <= status_q & en_q;
      rd_q     <= rd ? rd_mux : '0;
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

  // R8: a status bit only appears after an expiry event
  assert_status_source_R8: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q)) != '0) |-> ($past(irq_evt_i) != '0));
  // R9: an interrupt line never rises without its enable
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    ((irq_q & ~$past(en_q)) == '0));
  // R10: an undefined address reads zero
  assert_undef_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rd && req_addr == ADDR_W'(OFS_STATUS + WORD_STRIDE)) |-> (rd_q == '0));
endmodule

// File: rtl/percore_watchdog.sv
module percore_watchdog
  import wdog_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 64,
  parameter int PRESC_LOG2 = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] trap_o,
  output logic [NUM_CORES-1:0] rst_req_o
);
  logic                             tick;
  logic [NUM_CORES-1:0]             cfg_we, poke, irq_evt;
  logic [MODE_W-1:0]                cfg_mode;
  logic [LEN_W-1:0]                 cfg_len;
  logic [CNT_W-1:0]                 cfg_cnt;
  logic [NUM_CORES-1:0][MODE_W-1:0] mode_w;
  logic [NUM_CORES-1:0][LEN_W-1:0]  len_w;
  logic [NUM_CORES-1:0][CNT_W-1:0]  cnt_w;

  wdog_prescaler #(.PRESC_LOG2(PRESC_LOG2)) u_presc (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  wdog_regs #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mode_i(mode_w), .len_i(len_w), .cnt_i(cnt_w), .irq_evt_i(irq_evt),
    .cfg_we_o(cfg_we), .cfg_mode_o(cfg_mode), .cfg_len_o(cfg_len),
    .cfg_cnt_o(cfg_cnt), .poke_o(poke),
    .rd_data_o(rsp_rdata), .irq_o(irq_o)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    wdog_core_timer u_tmr (
      .clk(clk), .rst(rst), .tick_i(tick),
      .cfg_we_i(cfg_we[g]), .cfg_mode_i(cfg_mode),
      .cfg_len_i(cfg_len), .cfg_cnt_i(cfg_cnt),
      .poke_i(poke[g]),
      .mode_o(mode_w[g]), .len_o(len_w[g]), .cnt_o(cnt_w[g]),
      .irq_evt_o(irq_evt[g]), .trap_o(trap_o[g]), .rst_req_o(rst_req_o[g])
    );
  end
endmodule

// File: tb/percore_watchdog_bench.sv
module percore_watchdog_bench;
  localparam int NC = 4;
  localparam int AW = 17;
  localparam int DW = 64;
  localparam int PL = 3;
  localparam int WD_LIMIT = 60000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          b_valid = 1'b0, b_write = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic [NC-1:0] irq_o, trap_o, rst_req_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string phase = "R1";

  always #4 clk = ~clk;

  percore_watchdog #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW), .PRESC_LOG2(PL)) u_percore_watchdog (
    .clk(clk), .rst(rst), .req_valid(b_valid), .req_write(b_write),
    .req_addr(b_addr), .req_wdata(b_wdata), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o), .trap_o(trap_o), .rst_req_o(rst_req_o)
  );

  // ---------------- behavioural reference model ----------------
  int            m_presc;
  int            m_mode[NC], m_len[NC], m_cnt[NC], m_stage[NC];
  logic [NC-1:0] m_status, m_en, evt, e_irq, e_trap, e_rst;
  logic [DW-1:0] e_rdata;
  bit            tick;

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    for (int c = 0; c < NC; c++)
      if (a == AW'(8 * c)) begin
        v[1:0]   = 2'(m_mode[c]);
        v[19:4]  = 16'(m_len[c]);
        v[43:20] = 24'(m_cnt[c]);
      end
    if (a == AW'('h200)) v[NC-1:0] = m_status;
    if (a == AW'('h210) || a == AW'('h218)) v[NC-1:0] = m_en;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      live = 1'b1;
      m_presc = 0;
      for (int c = 0; c < NC; c++) begin
        m_mode[c] = 0; m_len[c] = 0; m_cnt[c] = 0; m_stage[c] = 0;
      end
      m_status = '0; m_en = '0;
      e_irq = '0; e_trap = '0; e_rst = '0; e_rdata = '0;
    end else begin
      e_rdata = (b_valid && !b_write) ? model_read(b_addr) : '0;
      e_irq   = m_status & m_en;
      e_trap  = '0;
      evt     = '0;
      tick    = (m_presc == (1 << PL) - 1);
      for (int c = 0; c < NC; c++) begin
        if (b_valid && b_write && b_addr == AW'(8 * c)) begin
          m_mode[c] = int'(b_wdata[1:0]);
          m_len[c]  = int'(b_wdata[19:4]);
          m_cnt[c]  = int'(b_wdata[43:20]);
        end else if (b_valid && b_write && b_addr == AW'('h10000 + 8 * c) && b_wdata[0]) begin
          m_cnt[c] = m_len[c] * 256;
          m_stage[c] = 0;
        end else if (tick && m_mode[c] != 0) begin
          if (m_cnt[c] == 0) begin
            m_cnt[c] = m_len[c] * 256;
            if (m_stage[c] < m_mode[c]) begin
              m_stage[c]++;
              if (m_stage[c] == 1) evt[c] = 1'b1;
              if (m_stage[c] == 2) e_trap[c] = 1'b1;
              if (m_stage[c] == 3) e_rst[c] = 1'b1;
            end
          end else begin
            m_cnt[c]--;
          end
        end
      end
      if (b_valid && b_write && b_addr == AW'('h200)) m_status = m_status & ~b_wdata[NC-1:0];
      m_status = m_status | evt;
      if (b_valid && b_write && b_addr == AW'('h218)) m_en = m_en | b_wdata[NC-1:0];
      if (b_valid && b_write && b_addr == AW'('h210)) m_en = m_en & ~b_wdata[NC-1:0];
      m_presc = (m_presc + 1) % (1 << PL);
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk({phase, " irq_o (R9)"}, DW'(irq_o), DW'(e_irq));
      chk({phase, " trap_o (R5)"}, DW'(trap_o), DW'(e_trap));
      chk({phase, " rst_req_o (R5)"}, DW'(rst_req_o), DW'(e_rst));
      chk({phase, " rsp_rdata (R10)"}, rsp_rdata, e_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    b_valid = 1'b1; b_write = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_valid = 1'b0; b_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    b_valid = 1'b1; b_write = 1'b0; b_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    b_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] d;
    idle(5);
    rst = 1'b0;

    phase = "R1";
    rd(AW'('h0), d);   chk("R1 cfg0 after reset", d, '0);
    rd(AW'('h200), d); chk("R1 status after reset", d, '0);
    rd(AW'('h218), d); chk("R1 enable after reset", d, '0);
    chk("R1 outputs after reset", DW'({irq_o, trap_o, rst_req_o}), '0);

    phase = "R2";
    wr(AW'('h8), 64'h8000_0ABC_DEF1_234C);
    rd(AW'('h8), d); chk("R2 cfg1 readback", d, 64'h0000_0ABC_DEF1_2340);
    phase = "R3";
    idle(40);
    rd(AW'('h8), d); chk("R3 mode 0 keeps count", d, 64'h0000_0ABC_DEF1_2340);

    phase = "R9";
    wr(AW'('h218), 64'hB);
    rd(AW'('h210), d); chk("R9 enable set", d, 64'hB);
    wr(AW'('h210), 64'h2);
    rd(AW'('h218), d); chk("R9 enable clear", d, 64'h9);

    phase = "R5";
    wr(AW'('h0), 64'h30_0003);
    idle(120);
    chk("R5 core0 reset request", DW'(rst_req_o[0]), 64'h1);
    rd(AW'('h200), d); chk("R5 core0 status", d, 64'h1);

    phase = "R8";
    wr(AW'('h200), 64'h1);
    rd(AW'('h200), d); chk("R8 status cleared", d, 64'h0);
    wr(AW'('h10000), 64'h1);
    idle(30);
    rd(AW'('h200), d); chk("R8 status fires again", d, 64'h1);
    chk("R5 reset request still held", DW'(rst_req_o[0]), 64'h1);

    phase = "R7";
    wr(AW'('h10), 64'h50_0013);
    idle(20);
    wr(AW'('h10010), 64'h2);
    rd(AW'('h10), d);
    wr(AW'('h10010), 64'h1);
    rd(AW'('h10), d);

    phase = "R4";
    for (int i = 0; i < 6; i++) begin
      idle(400);
      rd(AW'('h10), d);
    end

    phase = "R6";
    wr(AW'('h18), 64'h1);
    idle(60);
    chk("R6 mode1 no reset", DW'(rst_req_o[3]), 64'h0);
    wr(AW'('h18), 64'h2);
    wr(AW'('h10018), 64'h1);
    idle(60);
    chk("R6 mode2 no reset", DW'(rst_req_o[3]), 64'h0);

    phase = "R11";
    wr(AW'('h8), 64'h10_0003);
    idle(80);
    chk("R11 core1 reset, core3 none", DW'({rst_req_o[3], rst_req_o[1]}), 64'h1);

    phase = "R12";
    wr(AW'('h10), 64'h0);
    rd(AW'('h10), d); chk("R12 cfg write stops core2", d, 64'h0);

    phase = "R10";
    rd(AW'('h208), d);   chk("R10 undefined read", d, '0);
    rd(AW'('h10000), d); chk("R10 poke reads zero", d, '0);
    rd(AW'('h10020), d); chk("R10 absent core poke", d, '0);
    wr(AW'('h208), '1);
    wr(AW'('h201), '1);
    rd(AW'('h201), d);   chk("R10 misaligned read", d, '0);
    rd(AW'('h200), d);
    idle(10);

    finish_run();
  end
endmodule